// File: doc/BRIEF.md
# Hypervisor VS Interrupt Registers

This block holds the hypervisor-side registers that steer interrupts toward a virtual supervisor (VS) guest. Four CSRs sit behind one read/write port. A delegation register picks which VS interrupts go to the guest. An enable register gates them. A virtual-pending register lets the hypervisor inject external, timer and software interrupts. A combined pending register merges those injected bits with the platform's VS interrupt lines and the guest-external signals. Those guest-external signals are produced elsewhere and arrive as inputs.

Reads are combinational. When `csrRe` is high, `csrRdata` shows the selected register in the same cycle. Writes take effect at the rising clock edge when `csrWe` is high. Each register keeps only its legal bits. The software bit of the pending register is an alias for the virtual-pending software bit. A per-bit vector reports every interrupt that is pending, enabled and delegated at once. The trap logic outside the block uses that vector.

Top module: `hvi_csr_top`

## Requirements
- R1: Reads at 0x603 (delegation), 0x604 (enable), 0x608 (pending) and 0x645 (virtual pending) leave `csrIllegal` low. A read of any other address returns zero and raises `csrIllegal`. With `csrRe` low, `csrIllegal` is low.
- R2: In the delegation register only bits 10, 6 and 2 are writable. Bits 12, 9, 5 and 1, and every other bit except bit 13 (see R9), always read zero.
- R3: The virtual-pending register holds writable bits 10 (external), 6 (timer) and 2 (software). All three reset to 0 and every other bit reads zero.
- R4: Pending bit 12 is read-only and equals `geSummary`.
- R5: Pending bit 10 is read-only and equals virtual-pending bit 10 OR `geSelPend` OR `platVsExt`.
- R6: Pending bit 6 is read-only and equals virtual-pending bit 6 OR `platVsTmr`.
- R7: Pending bit 2 reads virtual-pending bit 2. A write to the pending register copies data bit 2 into virtual-pending bit 2 and ignores all other data bits.
- R8: The enable register has writable bits 12, 10, 6 and 2. All other bits except bit 13 read zero. The enable and delegation registers reset to zero.
- R9: Bit 13 of the delegation and enable registers is writable when `LcofWritable` is 1. When `LcofWritable` is 0 it reads zero.
- R10: `vsFwd` equals the pending value AND the enable register AND the delegation register, bit by bit.
- R11: A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWe | input | 1 | Write strobe |
| csrRe | input | 1 | Read strobe |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read data (zero when not reading) |
| csrIllegal | output | 1 | Read of an unmapped address |
| geSummary | input | 1 | Guest-external summary: some enabled guest interrupt is pending |
| geSelPend | input | 1 | Pending bit of the currently selected guest-external source |
| platVsExt | input | 1 | Platform VS external interrupt line |
| platVsTmr | input | 1 | Platform VS timer interrupt line |
| vsFwd | output | XLEN | Interrupts pending, enabled and delegated to VS |

## Verification
The assertions assume that the address, the strobes and the four interrupt inputs hold known values at each rising edge. The alias property also assumes that no other write to the virtual-pending register comes between a pending-register write and the read that follows it. The bench drives every input at the falling edge and never raises `csrRe` and `csrWe` in the same cycle. It always performs a read in the cycle right after the write it checks. Random data mixes mapped and unmapped addresses, including ones adjacent to the mapped ones.

// File: rtl/hvi_pkg.sv
package hvi_pkg;
  localparam logic [11:0] ADDR_DELEG = 12'h603;
  localparam logic [11:0] ADDR_EN    = 12'h604;
  localparam logic [11:0] ADDR_PEND  = 12'h608;
  localparam logic [11:0] ADDR_VIP   = 12'h645;

  localparam int BIT_SSW  = 2;
  localparam int BIT_STMR = 6;
  localparam int BIT_SEXT = 10;
  localparam int BIT_GEXT = 12;
  localparam int BIT_LCOF = 13;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DELEG,
    SEL_EN,
    SEL_PEND,
    SEL_VIP
  } rd_sel_e;

  typedef struct packed {
    logic    wrDeleg;
    logic    wrEn;
    logic    wrVip;
    logic    wrPendAlias;
    rd_sel_e rdSel;
  } hvi_strobe_t;
endpackage

// File: rtl/hvi_ctrl.sv
module hvi_ctrl
  import hvi_pkg::*;
(
  input  logic        csrWe,
  input  logic        csrRe,
  input  logic [11:0] csrAddr,
  output hvi_strobe_t strobe,
  output logic        illegal
);
  rd_sel_e decSel;

  always_comb begin
    unique case (csrAddr)
      ADDR_DELEG: decSel = SEL_DELEG;
      ADDR_EN:    decSel = SEL_EN;
      ADDR_PEND:  decSel = SEL_PEND;
      ADDR_VIP:   decSel = SEL_VIP;
      default:    decSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.wrDeleg     = csrWe && (decSel == SEL_DELEG);
    strobe.wrEn        = csrWe && (decSel == SEL_EN);
    strobe.wrVip       = csrWe && (decSel == SEL_VIP);
    strobe.wrPendAlias = csrWe && (decSel == SEL_PEND);
    strobe.rdSel       = csrRe ? decSel : SEL_NONE;
    illegal            = csrRe && (decSel == SEL_NONE);
  end
endmodule

// File: rtl/hvi_dpath.sv
module hvi_dpath
  import hvi_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit LcofWritable = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  hvi_strobe_t      strobe,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic             geSummary,
  input  logic             geSelPend,
  input  logic             platVsExt,
  input  logic             platVsTmr,
  output logic [XLEN-1:0]  rdData,
  output logic [XLEN-1:0]  vsFwd
);
  localparam logic [XLEN-1:0] VsBits   = (XLEN'(1) << BIT_SEXT) | (XLEN'(1) << BIT_STMR)
                                       | (XLEN'(1) << BIT_SSW);
  localparam logic [XLEN-1:0] LcofBit  = XLEN'(1) << BIT_LCOF;
  localparam logic [XLEN-1:0] SwBit    = XLEN'(1) << BIT_SSW;
  localparam logic [XLEN-1:0] DelegMsk = VsBits | (LcofWritable ? LcofBit : '0);
  localparam logic [XLEN-1:0] EnMsk    = VsBits | (XLEN'(1) << BIT_GEXT)
                                       | (LcofWritable ? LcofBit : '0);
  localparam logic [XLEN-1:0] VipMsk   = VsBits;

  logic [XLEN-1:0] delegQ, enQ, vipQ, pendVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delegQ <= '0;
      enQ    <= '0;
    end else begin
      if (strobe.wrDeleg) delegQ <= csrWdata & DelegMsk;
      if (strobe.wrEn)    enQ    <= csrWdata & EnMsk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   vipQ <= '0;
    else if (strobe.wrVip)       vipQ <= csrWdata & VipMsk;
    else if (strobe.wrPendAlias) vipQ <= (vipQ & ~SwBit) | (csrWdata & SwBit);
  end

  always_comb begin
    pendVal           = '0;
    pendVal[BIT_GEXT] = geSummary;
    pendVal[BIT_SEXT] = vipQ[BIT_SEXT] | geSelPend | platVsExt;
    pendVal[BIT_STMR] = vipQ[BIT_STMR] | platVsTmr;
    pendVal[BIT_SSW]  = vipQ[BIT_SSW];
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DELEG: rdData = delegQ;
      SEL_EN:    rdData = enQ;
      SEL_PEND:  rdData = pendVal;
      SEL_VIP:   rdData = vipQ;
      default:   rdData = '0;
    endcase
  end

  assign vsFwd = pendVal & enQ & delegQ;
endmodule

// File: rtl/hvi_csr_top.sv
module hvi_csr_top
  import hvi_pkg::*;
#(
  parameter int XLEN         = 64,
  parameter bit LcofWritable = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWe,
  input  logic            csrRe,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrIllegal,
  input  logic            geSummary,
  input  logic            geSelPend,
  input  logic            platVsExt,
  input  logic            platVsTmr,
  output logic [XLEN-1:0] vsFwd
);
  hvi_strobe_t strobe;

  hvi_ctrl u_ctrl (
    .csrWe   (csrWe),
    .csrRe   (csrRe),
    .csrAddr (csrAddr),
    .strobe  (strobe),
    .illegal (csrIllegal)
  );

  hvi_dpath #(.XLEN(XLEN), .LcofWritable(LcofWritable)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .csrWdata  (csrWdata),
    .geSummary (geSummary),
    .geSelPend (geSelPend),
    .platVsExt (platVsExt),
    .platVsTmr (platVsTmr),
    .rdData    (csrRdata),
    .vsFwd     (vsFwd)
  );
endmodule

// File: rtl/hvi_csr_chk.sv
module hvi_csr_chk
  import hvi_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrWe,
  input logic            csrRe,
  input logic [11:0]     csrAddr,
  input logic [XLEN-1:0] csrWdata,
  input logic [XLEN-1:0] csrRdata,
  input logic            csrIllegal,
  input logic            geSummary,
  input logic            geSelPend,
  input logic            platVsExt,
  input logic            platVsTmr,
  input logic [XLEN-1:0] vsFwd
);
  logic mapped;
  assign mapped = (csrAddr == ADDR_DELEG) || (csrAddr == ADDR_EN) ||
                  (csrAddr == ADDR_PEND)  || (csrAddr == ADDR_VIP);

  p_illegal_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && !mapped) |-> (csrIllegal && csrRdata == '0));
  p_legal_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!csrRe || mapped) |-> !csrIllegal);
  p_deleg_s_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrAddr == ADDR_DELEG) |->
      (!csrRdata[12] && !csrRdata[9] && !csrRdata[5] && !csrRdata[1]));
  p_vip_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrAddr == ADDR_VIP) |-> $countones(csrRdata) <=
      32'(csrRdata[10]) + 32'(csrRdata[6]) + 32'(csrRdata[2]));
  p_gext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrAddr == ADDR_PEND) |-> csrRdata[12] == geSummary);
  p_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrAddr == ADDR_PEND && (geSelPend || platVsExt)) |-> csrRdata[10]);
  p_stmr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csrRe && csrAddr == ADDR_PEND && platVsTmr) |-> csrRdata[6]);
  p_alias_r7: assert property (@(posedge clk) disable iff (!rstN)
    (csrWe && csrAddr == ADDR_PEND) ##1 (csrRe && !csrWe && csrAddr == ADDR_VIP)
      |-> csrRdata[2] == $past(csrWdata[2]));
  p_fwd_legal_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(vsFwd) <= 32'(vsFwd[13]) + 32'(vsFwd[10]) + 32'(vsFwd[6]) + 32'(vsFwd[2]));
endmodule

bind hvi_csr_top hvi_csr_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csrWe      (csrWe),
  .csrRe      (csrRe),
  .csrAddr    (csrAddr),
  .csrWdata   (csrWdata),
  .csrRdata   (csrRdata),
  .csrIllegal (csrIllegal),
  .geSummary  (geSummary),
  .geSelPend  (geSelPend),
  .platVsExt  (platVsExt),
  .platVsTmr  (platVsTmr),
  .vsFwd      (vsFwd)
);

// File: tb/tb_hvi_csr_top.sv
`timescale 1ns/1ps
module tb_hvi_csr_top;
  localparam int XLEN = 64;
  localparam logic [63:0] VS  = 64'h0000_0000_0000_0444;
  localparam logic [63:0] B13 = 64'h0000_0000_0000_2000;
  localparam logic [63:0] B12 = 64'h0000_0000_0000_1000;

  logic clk = 0, rstN = 0, csrWe = 0, csrRe = 0;
  logic [11:0] csrAddr = '0;
  logic [63:0] csrWdata = '0;
  logic geSummary = 0, geSelPend = 0, platVsExt = 0, platVsTmr = 0;
  logic [63:0] csrRdata, vsFwd, rdata0, fwd0;
  logic csrIllegal, illegal0;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [63:0] mDeleg = '0, mEn = '0, mVip = '0;

  always #5 clk = ~clk;

  hvi_csr_top #(.XLEN(XLEN)) dut (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrRe(csrRe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .geSummary(geSummary), .geSelPend(geSelPend), .platVsExt(platVsExt),
    .platVsTmr(platVsTmr), .vsFwd(vsFwd));

  hvi_csr_top #(.XLEN(XLEN), .LcofWritable(1'b0)) dutNoLcof (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrRe(csrRe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(rdata0), .csrIllegal(illegal0),
    .geSummary(geSummary), .geSelPend(geSelPend), .platVsExt(platVsExt),
    .platVsTmr(platVsTmr), .vsFwd(fwd0));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expPend();
    logic [63:0] p = '0;
    p[12] = geSummary;
    p[10] = mVip[10] | geSelPend | platVsExt;
    p[6]  = mVip[6] | platVsTmr;
    p[2]  = mVip[2];
    return p;
  endfunction

  function automatic logic [63:0] expRead(input logic [11:0] a);
    case (a)
      12'h603: return mDeleg;
      12'h604: return mEn;
      12'h608: return expPend();
      12'h645: return mVip;
      default: return '0;
    endcase
  endfunction

  function automatic bit isMapped(input logic [11:0] a);
    return a == 12'h603 || a == 12'h604 || a == 12'h608 || a == 12'h645;
  endfunction

  function automatic string tagOf(input logic [11:0] a);
    case (a)
      12'h603: return "R2";
      12'h604: return "R8";
      12'h608: return "R5";
      12'h645: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csrRe = 0; csrWe = 1; csrAddr = a; csrWdata = d;
    @(posedge clk);
    #1 csrWe = 0;
    case (a)
      12'h603: mDeleg = d & (VS | B13);
      12'h604: mEn    = d & (VS | B12 | B13);
      12'h645: mVip   = d & VS;
      12'h608: mVip[2] = d[2];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [11:0] a, input logic ge, input logic sel,
                    input logic ext, input logic tmr, input string tag);
    logic [63:0] e;
    @(negedge clk);
    csrWe = 0; csrRe = 1; csrAddr = a;
    geSummary = ge; geSelPend = sel; platVsExt = ext; platVsTmr = tmr;
    #1;
    e = expRead(a);
    chk(tag, csrRdata, e);
    chk("R1", {63'd0, csrIllegal}, {63'd0, !isMapped(a)});
    // R10: forwarded vector
    chk("R10", vsFwd, expPend() & mEn & mDeleg);
    // R9: no-lcof variant never shows bit 13
    chk("R9", rdata0, e & ~B13);
    chk("R9", fwd0, expPend() & mEn & mDeleg & ~B13);
  endtask

  function automatic logic [11:0] pickAddr();
    case ($urandom % 8)
      0: return 12'h603;
      1: return 12'h604;
      2: return 12'h608;
      3: return 12'h645;
      4: return 12'h605;
      5: return 12'h607;
      6: return 12'h644;
      default: return 12'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R3 and R8: reset values
    rd(12'h645, 0, 0, 0, 0, "R3");
    rd(12'h604, 0, 0, 0, 0, "R8");
    rd(12'h603, 0, 0, 0, 0, "R2");
    rd(12'h600, 0, 0, 0, 0, "R1");
    // R2 and R9: delegation mask
    wr(12'h603, '1);
    rd(12'h603, 0, 0, 0, 0, "R2");
    chk("R9", csrRdata[13], 1'b1);
    wr(12'h604, '1);
    rd(12'h604, 0, 0, 0, 0, "R8");
    // R4, R5, R6: pending sources
    rd(12'h608, 1, 0, 0, 0, "R4");
    rd(12'h608, 0, 1, 0, 0, "R5");
    rd(12'h608, 0, 0, 1, 0, "R5");
    rd(12'h608, 0, 0, 0, 1, "R6");
    // R7: write to pending touches only bit 2 of virtual pending
    wr(12'h608, '1);
    rd(12'h645, 0, 0, 0, 0, "R7");
    chk("R7", csrRdata, 64'h4);
    rd(12'h608, 0, 0, 0, 0, "R7");
    wr(12'h608, 64'hFFFF_FFFF_FFFF_FFFB);
    rd(12'h645, 0, 0, 0, 0, "R7");
    wr(12'h645, '1);
    rd(12'h608, 1, 0, 0, 0, "R10");
    // R11: unmapped writes change nothing
    wr(12'h646, '0);
    wr(12'h602, '0);
    rd(12'h603, 0, 0, 0, 0, "R11");
    rd(12'h604, 0, 0, 0, 0, "R11");
    rd(12'h645, 0, 0, 0, 0, "R11");
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      a = pickAddr();
      if ($urandom % 2) wr(a, {$urandom, $urandom});
      a = pickAddr();
      rd(a, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), tagOf(a));
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule